// File: doc/BRIEF.md
# Transmit Ping-Pong Packet Buffer

This block sits on the device side of a byte-wide synchronous link and gathers the bytes that an external system writes into packets for an upstream packet consumer. Two equal packet buffers alternate. One buffer takes new bytes while the other is being read out, and the roles swap whenever the filling buffer is handed over.

A buffer is handed over in three cases. It can become full. A programmable latency timer, counted in millisecond ticks, can expire after the last write. A send-immediate strobe, active low, can arrive. Each of the last two releases a partly filled buffer whatever its size. An empty buffer is never released.

The upstream side sees a valid flag, the packet length and the current byte. It takes one byte per cycle with a read strobe and is told which byte is the last. The writer sees a single flag that goes high while no byte can be accepted.

Top module: `tx_pp_buffer`

## Requirements
- R1: In the cycle after reset, `pkt_valid` and `tx_full` are both 0.
- R2: When the filling buffer reaches 512 bytes and the other buffer is free, it is released without any flush, and `pkt_len` reads 512.
- R3: With `tmo_ms` between 2 and 255, a non-empty filling buffer is released on the `tmo_ms`-th `ms_tick` after its most recent accepted write. Every accepted write restarts this count, and ticks do not count while the buffer is empty.
- R4: A `tmo_ms` value of 0 selects a 16-tick timeout, and a value of 1 is treated as 2 ticks.
- R5: A falling edge on `send_now_n` releases the non-empty filling buffer. Holding the pin low afterwards causes no further release.
- R6: A flush, whether from a strobe or a timeout, has no effect when the filling buffer holds no byte: `pkt_valid` stays 0.
- R7: While `pkt_valid` is 1, `pkt_len` equals the number of bytes in the released buffer (1 to 512). `pkt_data` presents those bytes in write order, advancing one byte per cycle with `pkt_rd`. `pkt_last` is 1 on the final byte, and the buffer is freed after that byte is read.
- R8: `tx_full` is 1 exactly when the filling buffer holds 512 bytes and the other buffer is still released. A write offered while `tx_full` is 1 is dropped.
- R9: Writes continue into the second buffer while the first is being read. A flush or a full condition that arises while the other buffer is still released is held until that buffer is freed, and is then served.
- R10: A byte written in the same cycle as a buffer swap is stored as the first byte of the new filling buffer. No byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write request |
| wr_data | input | 8 | Byte to store |
| tx_full | output | 1 | No buffer can accept a byte |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| tmo_ms | input | 8 | Latency timeout in ticks (0 selects 16, 1 acts as 2) |
| send_now_n | input | 1 | Send-immediate strobe, active low, edge detected |
| pkt_valid | output | 1 | A released packet is available |
| pkt_len | output | 10 | Byte count of the released packet |
| pkt_data | output | 8 | Current byte of the released packet |
| pkt_last | output | 1 | Current byte is the packet's final byte |
| pkt_rd | input | 1 | Consume the current byte |

## Verification
A continuous write stream can meet a buffer swap. The byte offered in the swap cycle must go to the new buffer, not the old one. The bench provokes this by keeping `wr_en` high for twenty cycles and dropping `send_now_n` together with the sixth byte. The flush is registered on that edge and the swap follows one edge later. The bench judges the result by requiring a first packet of exactly six bytes and a second packet that carries the remaining fourteen in order.

// File: rtl/tx_pp_pkg.sv
package tx_pp_pkg;
    parameter int PKT_BYTES   = 512;
    parameter int BYTE_W      = 8;
    parameter int TMO_W       = 8;
    parameter int TMO_DEFAULT = 16;
    parameter int TMO_MIN     = 2;
    parameter int BANKS       = 2;

    localparam int LEN_W  = $clog2(PKT_BYTES + 1);
    localparam int PTR_W  = $clog2(PKT_BYTES);
    localparam int ADDR_W = PTR_W + $clog2(BANKS);

    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] ptr;
    } drain_t;

    function automatic logic [TMO_W-1:0] eff_timeout(input logic [TMO_W-1:0] t);
        if (t == '0)
            return TMO_W'(TMO_DEFAULT);
        else if (t < TMO_W'(TMO_MIN))
            return TMO_W'(TMO_MIN);
        else
            return t;
    endfunction
endpackage

// File: rtl/tx_pp_store.sv
module tx_pp_store
    import tx_pp_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [PTR_W-1:0]  widx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rbank,
    input  logic [PTR_W-1:0]  ridx,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = BANKS * PKT_BYTES;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[{wbank, widx}] <= wdata;
    end

    assign rdata = mem[{rbank, ridx}];
endmodule

// File: rtl/tx_pp_latency.sv
module tx_pp_latency
    import tx_pp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             armed,
    input  logic             restart,
    input  logic [TMO_W-1:0] tmo_ms,
    input  logic             send_now_n,
    output logic             flush_req
);
    logic [TMO_W-1:0] tmr;
    logic [TMO_W-1:0] limit;
    logic [TMO_W:0]   nxt;
    logic             expire;
    logic             sn_q;
    logic             fall;

    assign limit  = eff_timeout(tmo_ms);
    assign nxt    = {1'b0, tmr} + 1'b1;
    assign expire = ms_tick && armed && !restart && (nxt >= {1'b0, limit});
    assign fall   = sn_q && !send_now_n;
    assign flush_req = expire || fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr  <= '0;
            sn_q <= 1'b1;
        end else begin
            sn_q <= send_now_n;
            if (restart || !armed || expire)
                tmr <= '0;
            else if (ms_tick)
                tmr <= nxt[TMO_W-1:0];
        end
    end
endmodule

// File: rtl/tx_pp_ctrl.sv
module tx_pp_ctrl
    import tx_pp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             flush_req,
    input  logic             pkt_rd,
    output logic             wr_acc,
    output logic             wbank,
    output logic [PTR_W-1:0] widx,
    output logic             swap,
    output logic [LEN_W-1:0] fill_cnt,
    output logic             tx_full,
    output drain_t           drn,
    output logic             rbank,
    output logic             last
);
    logic fsel;
    logic flush_pend;
    logic fill_full;
    logic pop;

    assign fill_full = (fill_cnt == LEN_W'(PKT_BYTES));
    assign swap      = !drn.busy && (fill_cnt != '0) && (fill_full || flush_pend);
    assign tx_full   = fill_full && drn.busy;
    assign wr_acc    = wr_en && !tx_full;
    assign wbank     = swap ? !fsel : fsel;
    assign widx      = swap ? '0 : fill_cnt[PTR_W-1:0];
    assign rbank     = !fsel;
    assign last      = (drn.ptr == PTR_W'(drn.len - 1'b1));
    assign pop       = drn.busy && pkt_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel       <= 1'b0;
            fill_cnt   <= '0;
            flush_pend <= 1'b0;
            drn        <= '0;
        end else begin
            if (swap) begin
                fsel     <= !fsel;
                fill_cnt <= LEN_W'(wr_acc);
            end else begin
                fill_cnt <= fill_cnt + LEN_W'(wr_acc);
            end

            if (swap)
                flush_pend <= 1'b0;
            else if (flush_req && (fill_cnt != '0 || wr_acc))
                flush_pend <= 1'b1;

            if (swap) begin
                drn.busy <= 1'b1;
                drn.len  <= fill_cnt;
                drn.ptr  <= '0;
            end else if (pop) begin
                if (last)
                    drn.busy <= 1'b0;
                else
                    drn.ptr <= drn.ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_pp_buffer.sv
module tx_pp_buffer
    import tx_pp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tx_full,
    input  logic              ms_tick,
    input  logic [TMO_W-1:0]  tmo_ms,
    input  logic              send_now_n,
    output logic              pkt_valid,
    output logic [LEN_W-1:0]  pkt_len,
    output logic [BYTE_W-1:0] pkt_data,
    output logic              pkt_last,
    input  logic              pkt_rd
);
    logic             wr_acc;
    logic             wbank;
    logic [PTR_W-1:0] widx;
    logic             swap;
    logic [LEN_W-1:0] fill_cnt;
    drain_t           drn;
    logic             rbank;
    logic             last;
    logic             flush_req;

    tx_pp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .flush_req (flush_req),
        .pkt_rd    (pkt_rd),
        .wr_acc    (wr_acc),
        .wbank     (wbank),
        .widx      (widx),
        .swap      (swap),
        .fill_cnt  (fill_cnt),
        .tx_full   (tx_full),
        .drn       (drn),
        .rbank     (rbank),
        .last      (last)
    );

    tx_pp_latency u_lat (
        .clk        (clk),
        .rst        (rst),
        .ms_tick    (ms_tick),
        .armed      (fill_cnt != '0),
        .restart    (wr_acc || swap),
        .tmo_ms     (tmo_ms),
        .send_now_n (send_now_n),
        .flush_req  (flush_req)
    );

    tx_pp_store u_store (
        .clk   (clk),
        .we    (wr_acc),
        .wbank (wbank),
        .widx  (widx),
        .wdata (wr_data),
        .rbank (rbank),
        .ridx  (drn.ptr),
        .rdata (pkt_data)
    );

    assign pkt_valid = drn.busy;
    assign pkt_len   = drn.len;
    assign pkt_last  = drn.busy && last;
endmodule

// File: rtl/tx_pp_buffer_chk.sv
module tx_pp_buffer_chk
    import tx_pp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             tx_full,
    input logic             pkt_valid,
    input logic             pkt_rd,
    input logic             pkt_last,
    input logic [LEN_W-1:0] pkt_len,
    input logic [LEN_W-1:0] fill_cnt
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!pkt_valid && !tx_full));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= LEN_W'(PKT_BYTES));

    assert_full_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_full && wr_en) |=> (fill_cnt == LEN_W'(PKT_BYTES)));

    assert_len_range_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_len != '0 && pkt_len <= LEN_W'(PKT_BYTES)));

    assert_len_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !(pkt_rd && pkt_last)) |=> (pkt_valid && $stable(pkt_len)));

    assert_empty_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!pkt_valid && fill_cnt == '0) |=> !pkt_valid);
endmodule

bind tx_pp_buffer tx_pp_buffer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .tx_full   (tx_full),
    .pkt_valid (pkt_valid),
    .pkt_rd    (pkt_rd),
    .pkt_last  (pkt_last),
    .pkt_len   (pkt_len),
    .fill_cnt  (fill_cnt)
);

// File: tb/tx_pp_buffer_tb.sv
module tx_pp_buffer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_full;
    logic       ms_tick = 1'b0;
    logic [7:0] tmo_ms = 8'd255;
    logic       send_now_n = 1'b1;
    logic       pkt_valid;
    logic [9:0] pkt_len;
    logic [7:0] pkt_data;
    logic       pkt_last;
    logic       pkt_rd = 1'b0;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] seq = 8'd0;
    logic [7:0] expq [$];

    always #2 clk = ~clk;

    tx_pp_buffer u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_full    (tx_full),
        .ms_tick    (ms_tick),
        .tmo_ms     (tmo_ms),
        .send_now_n (send_now_n),
        .pkt_valid  (pkt_valid),
        .pkt_len    (pkt_len),
        .pkt_data   (pkt_data),
        .pkt_last   (pkt_last),
        .pkt_rd     (pkt_rd)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1;
            wr_data = seq;
            expq.push_back(seq);
            seq = seq + 8'd1;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        cyc(2);
    endtask

    task automatic strobe();
        send_now_n = 1'b0;
        cyc(1);
        send_now_n = 1'b1;
        cyc(1);
    endtask

    task automatic read_pkt(input int exp_len, input string tag);
        for (int w = 0; w < 40 && !pkt_valid; w++) @(negedge clk);
        check(pkt_valid === 1'b1, {tag, " valid"}, int'(pkt_valid), 1);
        check(pkt_len == 10'(exp_len), {tag, " R7 length"}, int'(pkt_len), exp_len);
        for (int k = 0; k < exp_len; k++) begin
            logic [7:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : 8'hxx;
            check(pkt_data === e, {tag, " R7 data order"}, int'(pkt_data), int'(e));
            check(pkt_last === (k == exp_len - 1), {tag, " R7 last flag"}, int'(pkt_last),
                  int'(k == exp_len - 1));
            pkt_rd = 1'b1;
            @(negedge clk);
        end
        pkt_rd = 1'b0;
    endtask

    task automatic t_reset();
        check(pkt_valid === 1'b0, "R1 pkt_valid after reset", int'(pkt_valid), 0);
        check(tx_full === 1'b0, "R1 tx_full after reset", int'(tx_full), 0);
    endtask

    task automatic t_full_packet();
        tmo_ms = 8'd255;
        write_n(512);
        cyc(2);
        check(pkt_valid === 1'b1, "R2 full buffer released", int'(pkt_valid), 1);
        check(pkt_len == 10'd512, "R2 full length", int'(pkt_len), 512);
        read_pkt(512, "R2");
        cyc(2);
        check(pkt_valid === 1'b0, "R7 buffer freed", int'(pkt_valid), 0);
    endtask

    task automatic t_timeout();
        tmo_ms = 8'd5;
        write_n(3);
        repeat (4) tick();
        check(pkt_valid === 1'b0, "R3 no release before timeout", int'(pkt_valid), 0);
        write_n(1);
        repeat (4) tick();
        check(pkt_valid === 1'b0, "R3 write restarts timer", int'(pkt_valid), 0);
        tick();
        cyc(1);
        check(pkt_valid === 1'b1, "R3 release on timeout", int'(pkt_valid), 1);
        read_pkt(4, "R3");
    endtask

    task automatic t_tmo_special();
        tmo_ms = 8'd0;
        write_n(1);
        repeat (15) tick();
        check(pkt_valid === 1'b0, "R4 zero selects 16 (15 ticks)", int'(pkt_valid), 0);
        tick();
        cyc(1);
        check(pkt_valid === 1'b1, "R4 zero selects 16 (16 ticks)", int'(pkt_valid), 1);
        read_pkt(1, "R4 t0");
        tmo_ms = 8'd1;
        write_n(1);
        tick();
        check(pkt_valid === 1'b0, "R4 one acts as 2 (1 tick)", int'(pkt_valid), 0);
        tick();
        cyc(1);
        check(pkt_valid === 1'b1, "R4 one acts as 2 (2 ticks)", int'(pkt_valid), 1);
        read_pkt(1, "R4 t1");
        tmo_ms = 8'd255;
    endtask

    task automatic t_send_now();
        write_n(7);
        send_now_n = 1'b0;
        cyc(4);
        check(pkt_valid === 1'b1, "R5 strobe releases", int'(pkt_valid), 1);
        read_pkt(7, "R5");
        write_n(2);
        cyc(5);
        check(pkt_valid === 1'b0, "R5 held low gives one flush", int'(pkt_valid), 0);
        send_now_n = 1'b1;
        cyc(2);
        strobe();
        read_pkt(2, "R5 second");
    endtask

    task automatic t_empty_flush();
        strobe();
        cyc(3);
        check(pkt_valid === 1'b0, "R6 strobe on empty", int'(pkt_valid), 0);
        tmo_ms = 8'd2;
        repeat (5) tick();
        check(pkt_valid === 1'b0, "R6 ticks on empty", int'(pkt_valid), 0);
        tmo_ms = 8'd255;
        write_n(1);
        cyc(3);
        check(pkt_valid === 1'b0, "R3 idle ticks not counted", int'(pkt_valid), 0);
        strobe();
        read_pkt(1, "R6 follow");
    endtask

    task automatic t_pingpong();
        write_n(512);
        write_n(512);
        cyc(2);
        check(tx_full === 1'b1, "R8 both buffers full", int'(tx_full), 1);
        for (int i = 0; i < 3; i++) begin
            wr_en = 1'b1;
            wr_data = 8'hEE;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(tx_full === 1'b1, "R8 still full after dropped writes", int'(tx_full), 1);
        read_pkt(512, "R9 first");
        cyc(3);
        check(tx_full === 1'b0, "R8 space after drain", int'(tx_full), 0);
        read_pkt(512, "R8 second no dropped byte");
        write_n(512);
        write_n(5);
        strobe();
        cyc(5);
        check(pkt_len == 10'd512, "R9 flush deferred", int'(pkt_len), 512);
        read_pkt(512, "R9 busy drain");
        read_pkt(5, "R9 deferred flush");
    endtask

    task automatic t_collide();
        for (int i = 0; i < 20; i++) begin
            wr_en = 1'b1;
            wr_data = seq;
            expq.push_back(seq);
            seq = seq + 8'd1;
            if (i == 5) send_now_n = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        send_now_n = 1'b1;
        cyc(1);
        check(pkt_len == 10'd6, "R10 swap-cycle byte in new buffer", int'(pkt_len), 6);
        read_pkt(6, "R10 first");
        strobe();
        read_pkt(14, "R10 second");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_packet();
        t_timeout();
        t_tmo_special();
        t_send_now();
        t_empty_flush();
        t_pingpong();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule